// File: doc/BRIEF.md
# Dual Accumulator Register-Load Unit

This unit holds two 36-bit accumulators. Each one has a 32-bit body (upper half 31:16, lower half 15:0) and four guard bits (35:32). It executes one instruction: load an accumulator from a register. The 16-bit instruction word names the target accumulator, the half to write and a 6-bit source-register code. The unit presents the code on `src_code`, and the surrounding register file returns the register contents on `src_data` in the same cycle.

A normal load moves a 16-bit value into one half. Narrow sources are first widened by zero or sign extension. The unit then refreshes the guard bits from bit 31. An optional mode clears the lower half whenever the upper half is written. A normal load takes two cycles and leaves the flags alone.

Two codes name the 32-bit product and y registers. For these codes a separate path moves the full 32 bits, sign-extended to 36 bits, in one cycle and sets the N, Z, V and C flags.

Top module: `accload_unit`

## Requirements
- R1: After a synchronous active-low reset, both accumulators and all flags are zero, and `busy` and `dec_err` are low.
- R2: A word whose bits 15:11 differ from 01000, or whose bits 3:1 are not 000, is rejected. `dec_err` is high for the one cycle after acceptance, and no accumulator or flag changes.
- R3: Bit 10 of the word picks the target. The value 0 writes accumulator `acc1` and the value 1 writes `acc0`. The other accumulator is never changed.
- R4: Bit 0 of the word picks the half. The value 0 writes bits 31:16 and the value 1 writes bits 15:0. The half not named keeps its value.
- R5: After every load, bits 35:32 of the target each equal its bit 31.
- R6: Source codes are extended by range. Codes 0–7 and 34–63 supply `src_data[15:0]` unchanged. Codes 8–15 supply `src_data[7:0]` zero-extended. Codes 16–23 supply `src_data[7:0]` sign-extended.
- R7: When `clr_lo_en` is high at acceptance, a write to the upper half also clears bits 15:0. Writes to the lower half are not affected.
- R8: Codes 24–31 name write-only registers. They load the value zero through the normal two-cycle path, and `dec_err` pulses in the cycle after acceptance.
- R9: A normal load raises `busy` for the one cycle after acceptance. The target is written on the following edge. The flags do not change.
- R10: While `busy` is high, `instr_valid` is ignored, and the word presented then has no effect.
- R11: Code 32 (y) and code 33 (p) load `src_data[31:0]`, sign-extended to 36 bits, into the whole target on the accepting edge. Bit 0 is ignored and `busy` stays low.
- R12: The flags are `flags[3:0]` = {N, Z, V, C}. The one-cycle path sets N to bit 35 of the result and sets Z when all 36 bits are zero. It clears V and C. Nothing else changes the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word present; accepted when `busy` is low |
| instr | input | 16 | Instruction word |
| clr_lo_en | input | 1 | Clear-low-half-on-upper-write mode, sampled at acceptance |
| src_code | output | 6 | Source-register code taken from the word, for the register file |
| src_data | input | 32 | Contents of the register named by `src_code` |
| busy | output | 1 | Second cycle of a normal load is pending |
| dec_err | output | 1 | Pulse: malformed word or write-only source |
| acc0 | output | 36 | Accumulator a0 |
| acc1 | output | 36 | Accumulator a1 |
| flags | output | 4 | {N, Z, V, C} |

## Verification
The assertions assume that reset is held low for at least one clock edge before any word is presented. They also assume that `src_data` is a known value whenever `instr_valid` is high. The bench drives inputs only at falling edges. It always returns `src_data` alongside its word, and it holds reset low for several cycles at the start. Words offered during `busy` are deliberately well formed one-cycle loads. If the block wrongly accepted one, the error would show in the accumulators and the flags.

// File: rtl/accload_pkg.sv
// Shared widths, source-code classes and the accumulator merge rule.
// Assumes exactly two accumulators; only the constants below size the datapath.
package accload_pkg;

    localparam int unsigned HW    = 16;         // half-word width
    localparam int unsigned GW    = 4;          // guard bit count
    localparam int unsigned BW    = 2 * HW;     // accumulator body width
    localparam int unsigned AW    = BW + GW;    // full accumulator width
    localparam int unsigned CW    = 6;          // source code width
    localparam int unsigned NW    = 8;          // narrow register width
    localparam int unsigned NACC  = 2;          // accumulator count
    localparam int unsigned IDXW  = 1;          // accumulator index width
    localparam int unsigned FW    = 4;          // flag count

    localparam logic [4:0] OPC_HI = 5'b01000;  // required bits 15:11

    // Source code range boundaries
    localparam logic [CW-1:0] ZEXT_LO  = 6'd8;
    localparam logic [CW-1:0] SEXT_LO  = 6'd16;
    localparam logic [CW-1:0] WONLY_LO = 6'd24;
    localparam logic [CW-1:0] WIDE_LO  = 6'd32;
    localparam logic [CW-1:0] FULL2_LO = 6'd34;

    typedef enum logic [2:0] {
        SC_FULL  = 3'd0,
        SC_ZEXT  = 3'd1,
        SC_SEXT  = 3'd2,
        SC_WONLY = 3'd3,
        SC_WIDE  = 3'd4
    } src_class_e;

    typedef enum logic [1:0] {
        WK_HI   = 2'd0,
        WK_LO   = 2'd1,
        WK_FULL = 2'd2
    } wr_kind_e;

    // Map a source code onto its extension class.
    function automatic src_class_e classify(input logic [CW-1:0] code);
        if (code < ZEXT_LO)       return SC_FULL;
        else if (code < SEXT_LO)  return SC_ZEXT;
        else if (code < WONLY_LO) return SC_SEXT;
        else if (code < WIDE_LO)  return SC_WONLY;
        else if (code < FULL2_LO) return SC_WIDE;
        else                      return SC_FULL;
    endfunction

    // New accumulator value for a write of the given kind.
    function automatic logic [AW-1:0] acc_merge(
        input logic [AW-1:0] old,
        input wr_kind_e      kind,
        input logic [BW-1:0] data,
        input logic          clr
    );
        logic [BW-1:0] body;
        case (kind)
            WK_HI:   body = {data[HW-1:0], (clr ? {HW{1'b0}} : old[HW-1:0])};
            WK_LO:   body = {old[BW-1:HW], data[HW-1:0]};
            default: body = data;
        endcase
        return {{GW{body[BW-1]}}, body};
    endfunction

endpackage

// File: rtl/accload_decoder.sv
// Splits an instruction word into its fields and checks the fixed bits.
// Purely combinational; assumes the word is stable while instr_valid is high.
module accload_decoder
    import accload_pkg::*;
(
    input  logic [15:0]      instr,
    output logic             fmt_ok,
    output logic [IDXW-1:0]  acc_idx,
    output logic             half_lo,
    output logic [CW-1:0]    code,
    output src_class_e       cls
);

    // Field extraction and format check.
    always_comb begin
        fmt_ok  = (instr[15:11] == OPC_HI) && (instr[3:1] == 3'b000);
        acc_idx = instr[10] ? IDXW'(0) : IDXW'(1);   // 1 selects a0, 0 selects a1
        half_lo = instr[0];
        code    = instr[9:4];
        cls     = classify(code);
    end

endmodule

// File: rtl/accload_srcmux.sv
// Widens the returned register contents according to the source class.
// Write-only sources read as zero; wide sources pass all BW bits.
module accload_srcmux
    import accload_pkg::*;
(
    input  src_class_e       cls,
    input  logic [BW-1:0]    src_data,
    output logic [HW-1:0]    val16,
    output logic [BW-1:0]    wide
);

    // Extension of narrow sources.
    always_comb begin
        case (cls)
            SC_ZEXT:  val16 = {{(HW-NW){1'b0}}, src_data[NW-1:0]};
            SC_SEXT:  val16 = {{(HW-NW){src_data[NW-1]}}, src_data[NW-1:0]};
            SC_WONLY: val16 = '0;
            default:  val16 = src_data[HW-1:0];
        endcase
        wide = src_data;
    end

endmodule

// File: rtl/accload_bank.sv
// Holds NACC accumulators and the flag register behind one write port.
// Assumes at most one write per cycle; flags follow only full-width writes.
module accload_bank
    import accload_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      wr_idx,
    input  wr_kind_e             wr_kind,
    input  logic [BW-1:0]        wr_data,
    input  logic                 wr_clr,
    output logic [NACC*AW-1:0]   acc_flat,
    output logic [FW-1:0]        flags
);

    genvar gi;
    generate
        for (gi = 0; gi < NACC; gi++) begin : g_acc
            logic [AW-1:0] acc_q;

            // Register for one accumulator, written when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    acc_q <= '0;
                else if (wr_en && (wr_idx == IDXW'(gi)))
                    acc_q <= acc_merge(acc_q, wr_kind, wr_data, wr_clr);
            end

            assign acc_flat[gi*AW +: AW] = acc_q;
        end
    endgenerate

    logic [FW-1:0] flags_q;

    // Flag update from the one-cycle full-width move.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (wr_en && (wr_kind == WK_FULL))
            flags_q <= {wr_data[BW-1], (wr_data == '0), 1'b0, 1'b0};
    end

    assign flags = flags_q;

endmodule

// File: rtl/accload_unit.sv
// Register-to-accumulator load unit: decode, source widening, two-cycle
// half-word path and one-cycle full-width path. Assumes src_data answers
// src_code in the same cycle. New words are taken only while busy is low.
module accload_unit
    import accload_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           instr_valid,
    input  logic [15:0]    instr,
    input  logic           clr_lo_en,
    output logic [5:0]     src_code,
    input  logic [31:0]    src_data,
    output logic           busy,
    output logic           dec_err,
    output logic [35:0]    acc0,
    output logic [35:0]    acc1,
    output logic [3:0]     flags
);

    logic             fmt_ok;
    logic [IDXW-1:0]  d_idx;
    logic             d_lo;
    logic [CW-1:0]    d_code;
    src_class_e       d_cls;
    logic [HW-1:0]    val16;
    logic [BW-1:0]    wide;

    accload_decoder u_dec (
        .instr   (instr),
        .fmt_ok  (fmt_ok),
        .acc_idx (d_idx),
        .half_lo (d_lo),
        .code    (d_code),
        .cls     (d_cls)
    );

    accload_srcmux u_src (
        .cls      (d_cls),
        .src_data (src_data),
        .val16    (val16),
        .wide     (wide)
    );

    logic accept, go_fast, go_slow;
    logic busy_q, err_q;
    logic [IDXW-1:0] p_idx;
    logic            p_lo;
    logic            p_clr;
    logic [HW-1:0]   p_val;

    // Acceptance and path choice for the word on the input.
    always_comb begin
        accept  = instr_valid && !busy_q;
        go_fast = accept && fmt_ok && (d_cls == SC_WIDE);
        go_slow = accept && fmt_ok && (d_cls != SC_WIDE);
    end

    // Sequencer: hold a half-word load for its second cycle, flag bad words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            p_idx  <= '0;
            p_lo   <= 1'b0;
            p_clr  <= 1'b0;
            p_val  <= '0;
        end else begin
            busy_q <= go_slow;
            err_q  <= accept && (!fmt_ok || (d_cls == SC_WONLY));
            if (go_slow) begin
                p_idx <= d_idx;
                p_lo  <= d_lo;
                p_clr <= clr_lo_en;
                p_val <= val16;
            end
        end
    end

    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    wr_kind_e        wr_kind;
    logic [BW-1:0]   wr_data;
    logic            wr_clr;

    // Write-port mux: the pending half-word load or the one-cycle move.
    always_comb begin
        wr_en = busy_q || go_fast;
        if (busy_q) begin
            wr_idx  = p_idx;
            wr_kind = p_lo ? WK_LO : WK_HI;
            wr_data = {{HW{1'b0}}, p_val};
            wr_clr  = p_clr;
        end else begin
            wr_idx  = d_idx;
            wr_kind = WK_FULL;
            wr_data = wide;
            wr_clr  = 1'b0;
        end
    end

    logic [NACC*AW-1:0] acc_flat;

    accload_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_kind  (wr_kind),
        .wr_data  (wr_data),
        .wr_clr   (wr_clr),
        .acc_flat (acc_flat),
        .flags    (flags)
    );

    assign acc0     = acc_flat[0*AW +: AW];
    assign acc1     = acc_flat[1*AW +: AW];
    assign busy     = busy_q;
    assign dec_err  = err_q;
    assign src_code = d_code;

endmodule

// File: rtl/accload_checker.sv
// Temporal checks on the load unit's ports, attached by bind.
module accload_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic        busy,
    input logic        dec_err,
    input logic [35:0] acc0,
    input logic [35:0] acc1,
    input logic [3:0]  flags
);

    p_guard_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc0[35:32] == {4{acc0[31]}}) && (acc1[35:32] == {4{acc1[31]}}));

    p_busy_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_slow_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(flags));

    p_err_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (acc0 == $past(acc0)) && (acc1 == $past(acc1)));

    p_vc_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1:0] == 2'b00);

    p_busy_needs_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_valid));

endmodule

bind accload_unit accload_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .busy        (busy),
    .dec_err     (dec_err),
    .acc0        (acc0),
    .acc1        (acc1),
    .flags       (flags)
);

// File: tb/accload_unit_tb.sv
// Sweeps every source code, target, half and clear mode, plus bad words,
// against an arithmetic model kept in the bench.
module accload_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        clr_lo_en = 1'b0;
    logic [5:0]  src_code;
    logic [31:0] src_data = '0;
    logic        busy, dec_err;
    logic [35:0] acc0, acc1;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [35:0] m_acc [2];
    logic [3:0]  m_flags;

    always #5 clk = ~clk;

    accload_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .clr_lo_en(clr_lo_en), .src_code(src_code), .src_data(src_data),
        .busy(busy), .dec_err(dec_err), .acc0(acc0), .acc1(acc1), .flags(flags)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(acc0 === m_acc[0], tag, 64'(acc0), 64'(m_acc[0]));
        chk(acc1 === m_acc[1], tag, 64'(acc1), 64'(m_acc[1]));
        chk(flags === m_flags, {tag, " flags R12"}, 64'(flags), 64'(m_flags));
    endtask

    // Run one word; poke offers a one-cycle move while busy (R10).
    task automatic run(input logic [15:0] w, input logic [31:0] d, input bit clr, input bit poke);
        bit fmt, wonly, wide;
        int code, idx;
        logic [15:0] v;
        string tag;
        fmt   = (w[15:11] == 5'b01000) && (w[3:1] == 3'b000);
        code  = int'(w[9:4]);
        idx   = w[10] ? 0 : 1;
        wonly = (code >= 24) && (code < 32);
        wide  = (code == 32) || (code == 33);
        if (code < 8 || code >= 34)  begin v = d[15:0]; tag = w[0] ? "R4" : (clr ? "R7" : "R3"); end
        else if (code < 16)          begin v = {8'h00, d[7:0]}; tag = "R6"; end
        else if (code < 24)          begin v = {{8{d[7]}}, d[7:0]}; tag = "R6"; end
        else                         begin v = 16'h0000; tag = "R8"; end

        @(negedge clk);
        instr = w; src_data = d; clr_lo_en = clr; instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (!fmt) begin
            instr_valid = 1'b0;
            chk(dec_err === 1'b1, "R2 dec_err", 64'(dec_err), 64'd1);
            chk(busy === 1'b0, "R2 busy", 64'(busy), 64'd0);
            chk_state("R2 no change");
            return;
        end
        if (wide) begin
            instr_valid = 1'b0;
            m_acc[idx] = {{4{d[31]}}, d};
            m_flags = {d[31], (d == 32'h0), 2'b00};
            chk(busy === 1'b0, "R11 busy", 64'(busy), 64'd0);
            chk(dec_err === 1'b0, "R11 dec_err", 64'(dec_err), 64'd0);
            chk_state("R11 wide load");
            return;
        end
        chk(busy === 1'b1, "R9 busy", 64'(busy), 64'd1);
        chk(dec_err === wonly, "R8 dec_err", 64'(dec_err), 64'(wonly));
        chk_state("R9 not yet written");
        if (poke) begin
            instr = {5'b01000, 1'b0, 6'd32, 4'b0000};
            src_data = 32'h0000_0000;
        end else begin
            instr_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        if (w[0])
            m_acc[idx] = {{4{m_acc[idx][31]}}, m_acc[idx][31:16], v};
        else
            m_acc[idx] = {{4{v[15]}}, v, (clr ? 16'h0000 : m_acc[idx][15:0])};
        chk(busy === 1'b0, "R9 busy drop", 64'(busy), 64'd0);
        chk_state(poke ? "R10 ignored" : tag);
        chk((acc0[35:32] === {4{acc0[31]}}) && (acc1[35:32] === {4{acc1[31]}}),
            "R5 guard", 64'({acc1[35:31], acc0[35:31]}), 64'h0);
    endtask

    initial begin
        m_acc[0] = '0; m_acc[1] = '0; m_flags = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(acc0 === 36'h0 && acc1 === 36'h0, "R1 acc reset", 64'({acc1, acc0}), 64'h0);
        chk(flags === 4'h0 && busy === 1'b0 && dec_err === 1'b0, "R1 ctl reset",
            64'({flags, busy, dec_err}), 64'h0);
        rst_n = 1'b1;

        // Guard bits with a negative upper half, then a lower-half write.
        run(16'h4000 | 16'(0 << 4), 32'h0000_8001, 1'b0, 1'b0);
        run(16'h4001, 32'h0000_1234, 1'b0, 1'b0);
        // Zero result through the one-cycle path sets Z.
        run({5'b01000, 1'b1, 6'd33, 4'b0000}, 32'h0, 1'b0, 1'b0);
        run({5'b01000, 1'b0, 6'd32, 4'b0001}, 32'h8000_0001, 1'b0, 1'b0);

        for (int n = 0; n < 512; n++) begin
            logic [5:0]  c;
            logic [31:0] d;
            c = 6'(n >> 3);
            d = (32'h9E37_79B9 * 32'(n + 1)) ^ 32'(n << 7);
            run({5'b01000, n[2], c, 3'b000, n[1]}, d, n[0], (n % 4) == 3);
        end

        // Malformed words: wrong opcode bits or nonzero bits 3:1.
        run(16'h0000, 32'h1111_1111, 1'b0, 1'b0);
        run(16'h4802, 32'h2222_2222, 1'b0, 1'b0);
        run(16'hC010, 32'h3333_3333, 1'b0, 1'b0);
        run(16'h4208, 32'h4444_4444, 1'b0, 1'b0);
        run(16'h4004, 32'h5555_5555, 1'b0, 1'b0);

        @(negedge clk);
        chk(dec_err === 1'b0, "R2 pulse ends", 64'(dec_err), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule